// File: doc/BRIEF.md
# Event Timestamp Snapshot Unit

This block keeps a free-running 64-bit time base and records its value when a frame is sent or received on either of two message channels. Each channel has a single-cycle event input. When that input pulses, the current time value is copied into that channel's 64-bit snapshot. At the same edge the channel's valid flag is raised.

Firmware reads the snapshot as two 32-bit words over a plain register bus. The read data follows the address in the same cycle. A later event is not blocked by a pending valid flag: it replaces the stored time and raises a sticky overrun flag. Firmware therefore checks overrun before and after reading the upper word, so it can tell whether the two halves belong to the same event. Both flags are cleared by writing a one to them.

Top module: `evt_stamp_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every snapshot word and the status word read as zero, and the time base holds its reset value TIME_INIT (zero by default).
- R2: The time base increases by one every clock and wraps from all ones to zero. An event pulse on channel c in a cycle stores the time value of that cycle as the channel's snapshot.
- R3: Channel c's lower snapshot word, time bits 31:0, reads at offset 0x144 + 0x10*c. The upper word, time bits 63:32, reads at offset 0x148 + 0x10*c. Read data is combinational in the address.
- R4: The status word at offset 0x140 shows channel c's valid flag at bit 2c. A capture sets it. Only a write to 0x140 with bit 2c at one clears it, and writing zero to that bit has no effect.
- R5: A capture while valid is already set still replaces the stored snapshot with the new time value.
- R6: Channel c's overrun flag, at status bit 2c+1, is set by a capture that finds valid already set. It stays set until a write to 0x140 with bit 2c+1 at one.
- R7: When a capture and a clear of valid fall in the same cycle, valid stays set. Overrun is set in that cycle only if valid was set before it.
- R8: An event or a clear on one channel leaves the other channel's snapshot and flags unchanged.
- R9: Reads of any unmapped offset return zero. Writes to snapshot words or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the time base counts on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_CH | Single-cycle frame event, one bit per channel |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The bench builds the block with two channels, a 64-bit time base and TIME_INIT set to 0xFFFF_FFFF_FFFF_FF80. This start value puts an all-ones upper word and the wrap to zero within about a hundred cycles, so captures are taken on both sides of the carry into the upper half. Keeping two channels places channel 1's words at the second stride and leaves the gap offsets between and after them as unmapped cases.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;
    localparam int CH_IDX_W = 4;

    localparam logic [BUS_AW-1:0] STATUS_OFS = 12'h140;
    localparam logic [BUS_AW-1:0] CH_STRIDE  = 12'h010;
    localparam logic [3:0]        LO_SUB     = 4'h4;
    localparam logic [3:0]        HI_SUB     = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_SNAP_LO,
        SEL_SNAP_HI
    } sel_kind_t;

    typedef struct packed {
        sel_kind_t             kind;
        logic [CH_IDX_W-1:0]   ch;
    } reg_sel_t;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_t decode_addr(input logic [BUS_AW-1:0] addr,
                                             input int nch);
        reg_sel_t          sel;
        logic [BUS_AW-1:0] rel;
        logic [BUS_AW-1:0] span;
        sel.kind = SEL_NONE;
        sel.ch   = '0;
        rel  = addr - STATUS_OFS;
        span = BUS_AW'(nch) * CH_STRIDE;
        if (addr == STATUS_OFS) begin
            sel.kind = SEL_STATUS;
        end else if (addr > STATUS_OFS && rel < span) begin
            sel.ch = rel[CH_IDX_W+3:4];
            if (rel[3:0] == LO_SUB) begin
                sel.kind = SEL_SNAP_LO;
            end else if (rel[3:0] == HI_SUB) begin
                sel.kind = SEL_SNAP_HI;
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/evt_stamp_timebase.sv
module evt_stamp_timebase #(
    parameter int          TIME_W    = 64,
    parameter logic [63:0] TIME_INIT = 64'h0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] time_q
);

    localparam logic [TIME_W-1:0] INIT_V = TIME_INIT[TIME_W-1:0];
    localparam logic [TIME_W-1:0] ONE_V  = TIME_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= INIT_V;
        end else begin
            time_q <= time_q + ONE_V;
        end
    end

endmodule

// File: rtl/evt_stamp_channel.sv
module evt_stamp_channel #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [TIME_W-1:0] time_i,
    input  logic              clr_valid,
    input  logic              clr_ovr,
    output logic              valid,
    output logic              ovr,
    output logic [TIME_W-1:0] snap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            ovr   <= 1'b0;
            snap  <= '0;
        end else if (evt) begin
            snap  <= time_i;
            valid <= 1'b1;
            if (valid) begin
                ovr <= 1'b1;
            end else if (clr_ovr) begin
                ovr <= 1'b0;
            end
        end else begin
            if (clr_valid) begin
                valid <= 1'b0;
            end
            if (clr_ovr) begin
                ovr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/evt_stamp_regs.sv
module evt_stamp_regs
    import evt_stamp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TIME_W = 64
) (
    input  bus_req_t                       req,
    input  logic [NUM_CH-1:0]              valid_v,
    input  logic [NUM_CH-1:0]              ovr_v,
    input  logic [NUM_CH-1:0][TIME_W-1:0]  snap_v,
    output logic [NUM_CH-1:0]              clr_valid,
    output logic [NUM_CH-1:0]              clr_ovr,
    output logic [BUS_DW-1:0]              rdata
);

    localparam int STAT_BITS = 2 * NUM_CH;

    reg_sel_t sel;
    logic     status_wr;
    logic     wdata_unused;

    assign sel          = decode_addr(req.addr, NUM_CH);
    assign status_wr    = req.wr && (sel.kind == SEL_STATUS);
    assign wdata_unused = ^req.wdata[BUS_DW-1:STAT_BITS];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
            assign clr_valid[c] = status_wr && req.wdata[2*c];
            assign clr_ovr[c]   = status_wr && req.wdata[2*c+1];
        end
    endgenerate

    always_comb begin
        logic [63:0] ext;
        rdata = '0;
        ext   = '0;
        case (sel.kind)
            SEL_STATUS: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    rdata[2*c]   = valid_v[c];
                    rdata[2*c+1] = ovr_v[c];
                end
            end
            SEL_SNAP_LO, SEL_SNAP_HI: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (sel.ch == CH_IDX_W'(c)) begin
                        ext = 64'(snap_v[c]);
                    end
                end
                rdata = (sel.kind == SEL_SNAP_LO) ? ext[31:0] : ext[63:32];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
    import evt_stamp_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int          TIME_W    = 64,
    parameter logic [63:0] TIME_INIT = 64'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] evt_pulse,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic [TIME_W-1:0]             time_q;
    logic [NUM_CH-1:0]             valid_v;
    logic [NUM_CH-1:0]             ovr_v;
    logic [NUM_CH-1:0][TIME_W-1:0] snap_v;
    logic [NUM_CH-1:0]             clr_valid;
    logic [NUM_CH-1:0]             clr_ovr;
    bus_req_t                      req;

    assign req.wr    = bus_wr;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;

    evt_stamp_timebase #(
        .TIME_W    (TIME_W),
        .TIME_INIT (TIME_INIT)
    ) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .time_q (time_q)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            evt_stamp_channel #(
                .TIME_W (TIME_W)
            ) u_channel (
                .clk       (clk),
                .rst       (rst),
                .evt       (evt_pulse[c]),
                .time_i    (time_q),
                .clr_valid (clr_valid[c]),
                .clr_ovr   (clr_ovr[c]),
                .valid     (valid_v[c]),
                .ovr       (ovr_v[c]),
                .snap      (snap_v[c])
            );
        end
    endgenerate

    evt_stamp_regs #(
        .NUM_CH (NUM_CH),
        .TIME_W (TIME_W)
    ) u_regs (
        .req       (req),
        .valid_v   (valid_v),
        .ovr_v     (ovr_v),
        .snap_v    (snap_v),
        .clr_valid (clr_valid),
        .clr_ovr   (clr_ovr),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/evt_stamp_checker.sv
module evt_stamp_checker
    import evt_stamp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TIME_W = 64
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CH-1:0]             evt_pulse,
    input logic [11:0]                   bus_addr,
    input logic                          bus_wr,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic [TIME_W-1:0]             time_q,
    input logic [NUM_CH-1:0]             valid_v,
    input logic [NUM_CH-1:0]             ovr_v,
    input logic [NUM_CH-1:0][TIME_W-1:0] snap_v
);

    logic stat_hit;
    logic mapped;
    assign stat_hit = bus_addr == STATUS_OFS;
    always_comb begin
        mapped = stat_hit;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == STATUS_OFS + 12'(16 * c) + 12'h4 ||
                bus_addr == STATUS_OFS + 12'(16 * c) + 12'h8) begin
                mapped = 1'b1;
            end
        end
    end

    // R2: time base advances by one each clock
    p_time_step_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> time_q == $past(time_q) + TIME_W'(1));

    // R9: unmapped offsets read zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == 32'h0);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            // R2: capture stores the time of the event cycle
            p_capture_value_r2: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[c] |=> snap_v[c] == $past(time_q));

            // R9: snapshot only moves on its own event
            p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
                !evt_pulse[c] |=> $stable(snap_v[c]));

            // R4: valid stays without a clearing write
            p_valid_sticky_r4: assert property (@(posedge clk) disable iff (rst)
                valid_v[c] && !(bus_wr && stat_hit && bus_wdata[2*c]) |=> valid_v[c]);

            // R7: capture always leaves valid set
            p_capture_wins_r7: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[c] |=> valid_v[c]);

            // R6: capture over a pending valid raises overrun
            p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst)
                evt_pulse[c] && valid_v[c] |=> ovr_v[c]);

            // R6: overrun sticky until written one
            p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
                ovr_v[c] && !(bus_wr && stat_hit && bus_wdata[2*c+1]) |=> ovr_v[c]);
        end
    endgenerate

endmodule

bind evt_stamp_unit evt_stamp_checker #(
    .NUM_CH (NUM_CH),
    .TIME_W (TIME_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .time_q    (time_q),
    .valid_v   (valid_v),
    .ovr_v     (ovr_v),
    .snap_v    (snap_v)
);

// File: tb/test_evt_stamp_unit.sv
module test_evt_stamp_unit;

    localparam logic [63:0] T0 = 64'hFFFF_FFFF_FFFF_FF80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  evt_pulse = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [63:0] m_time;
    logic [63:0] m_snap [2];
    bit          m_valid [2];
    bit          m_ovr [2];

    always #2 clk = ~clk;

    evt_stamp_unit #(
        .NUM_CH    (2),
        .TIME_W    (64),
        .TIME_INIT (T0)
    ) i_evt_stamp_unit (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] expect_read(input logic [11:0] a);
        case (a)
            12'h140: return {28'h0, m_ovr[1], m_valid[1], m_ovr[0], m_valid[0]};
            12'h144: return m_snap[0][31:0];
            12'h148: return m_snap[0][63:32];
            12'h154: return m_snap[1][31:0];
            12'h158: return m_snap[1][63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input logic [1:0] ev, input logic [11:0] a,
                        input logic w, input logic [31:0] d, input string tag);
        logic [31:0] exp_v;
        evt_pulse = ev;
        bus_addr  = a;
        bus_wr    = w;
        bus_wdata = d;
        #1;
        exp_v = rst ? 32'h0 : expect_read(a);
        vectors++;
        if (bus_rdata !== exp_v) begin
            miscompares++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp_v);
        end
        @(posedge clk);
        if (rst) begin
            m_time = T0;
            for (int c = 0; c < 2; c++) begin
                m_snap[c] = '0; m_valid[c] = 0; m_ovr[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (ev[c]) begin
                    if (m_valid[c]) m_ovr[c] = 1;
                    else if (w && a == 12'h140 && d[2*c+1]) m_ovr[c] = 0;
                    m_snap[c]  = m_time;
                    m_valid[c] = 1;
                end else if (w && a == 12'h140) begin
                    if (d[2*c])   m_valid[c] = 0;
                    if (d[2*c+1]) m_ovr[c]   = 0;
                end
            end
            m_time = m_time + 64'd1;
        end
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        step(2'b00, 12'h140, 0, 0, tag);
        step(2'b00, 12'h144, 0, 0, tag);
        step(2'b00, 12'h148, 0, 0, tag);
        step(2'b00, 12'h154, 0, 0, tag);
        step(2'b00, 12'h158, 0, 0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(2'b11, 12'h144, 0, 0, "R1");
        rst = 1'b0;
        sweep("R1");
        // R2 R3: capture before the wrap, upper word all ones
        step(2'b01, 12'h148, 0, 0, "R2");
        sweep("R3");
        // R4: writing zero leaves valid
        step(2'b00, 12'h140, 1, 32'h0, "R4");
        step(2'b00, 12'h140, 1, 32'hFFFF_FFF0, "R4");
        step(2'b00, 12'h140, 0, 0, "R4");
        // R9: writes to snapshot and unmapped offsets ignored
        step(2'b00, 12'h144, 1, 32'hDEAD_BEEF, "R9");
        step(2'b00, 12'h148, 1, 32'h1234_5678, "R9");
        step(2'b00, 12'h14C, 1, 32'hFFFF_FFFF, "R9");
        step(2'b00, 12'h150, 0, 0, "R9");
        step(2'b00, 12'h15C, 0, 0, "R9");
        step(2'b00, 12'h000, 0, 0, "R9");
        step(2'b00, 12'hFFC, 0, 0, "R9");
        step(2'b00, 12'h164, 0, 0, "R9");
        sweep("R9");
        // R4: write one clears valid
        step(2'b00, 12'h140, 1, 32'h1, "R4");
        sweep("R4");
        // R2: run across the wrap, then capture channel 1
        for (int i = 0; i < 120; i++) step(2'b00, 12'h148, 0, 0, "R2");
        step(2'b10, 12'h158, 0, 0, "R2");
        sweep("R8");
        // R5 R6: second capture on channel 1 overwrites and flags overrun
        for (int i = 0; i < 3; i++) step(2'b00, 12'h154, 0, 0, "R5");
        step(2'b10, 12'h154, 0, 0, "R5");
        sweep("R6");
        step(2'b00, 12'h140, 1, 32'h4, "R6");
        step(2'b00, 12'h140, 0, 0, "R6");
        step(2'b00, 12'h140, 1, 32'h8, "R6");
        sweep("R6");
        // R7: capture and clear together, valid previously clear
        step(2'b01, 12'h140, 1, 32'h1, "R7");
        sweep("R7");
        // R7: capture and clear together, valid previously set
        step(2'b01, 12'h140, 1, 32'h3, "R7");
        sweep("R7");
        // R8: clearing channel 0 only
        step(2'b00, 12'h140, 1, 32'h3, "R8");
        sweep("R8");
        // R8: both channels at once
        step(2'b11, 12'h140, 0, 0, "R8");
        step(2'b01, 12'h144, 0, 0, "R8");
        sweep("R8");
        step(2'b00, 12'h140, 1, 32'hF, "R4");
        sweep("R4");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule